// File: doc/BRIEF.md
# Power-Good Latched Frequency Strap Decoder

This block fixes the host clock frequency selection of a clock generator from board straps. Three select straps (`fs_a`, `fs_b`, `fs_c`) and a table-mode strap (`tbl_sel`) are sampled exactly once. That happens on the first clock edge at which the active-low power-good input `pg_n`, after a two-flop synchronizer, reads low. From that point the captured selection is frozen. Later changes on the straps or on `pg_n` have no effect until the asynchronous reset `rst` is asserted again.

The captured table-mode strap chooses between two decode tables. With `tbl_sel` latched at 0, all three select straps form the index. With `tbl_sel` latched at 1, only `fs_b` and `fs_a` take part. The other clock domains (SRC, PCI, REF, USB) always report fixed frequency codes. Every frequency is given as a 3-bit code: 0 = 100 MHz, 1 = 133 MHz, 2 = 200 MHz, 3 = 266 MHz, 4 = 33 MHz, 5 = 14.318 MHz, 6 = 48 MHz.

Top module: `strap_freq_latch`

## Requirements
- R1: While `rst` is high, and after it is released until a capture takes place, `freq_valid` = 0, `rsv_flag` = 0 and `cpu_code` = 0 (100 MHz).
- R2: If `pg_n` is driven low ahead of rising edge k, the capture takes place on rising edge k+2, using the strap values present at that edge. `freq_valid` is 0 after edge k+1 and 1 after edge k+2.
- R3: Once `freq_valid` is 1, any change on `pg_n`, `fs_a`, `fs_b`, `fs_c` or `tbl_sel` leaves `cpu_code`, `rsv_flag` and `freq_valid` unchanged until reset.
- R4: With `tbl_sel` captured as 0, the index is {fs_c,fs_b,fs_a}. The decode is 101 to code 0, 001 to code 1, 010 to code 2 and 000 to code 3.
- R5: With `tbl_sel` captured as 1, the index is {fs_b,fs_a} and `fs_c` is ignored. The decode is 00 to code 0, 01 to code 1 and 10 to code 2.
- R6: Any captured combination that R4 or R5 does not list sets `rsv_flag` = 1 and gives `cpu_code` = 0. This covers 110 (the reserved entry), 011, 100 and 111 with `tbl_sel` 0, and 11 with `tbl_sel` 1. A listed combination gives `rsv_flag` = 0.
- R7: `src_code` = 0, `pci_code` = 4, `ref_code` = 5 and `usb_code` = 6 at all times.
- R8: Raising `rst` clears `freq_valid` at once, without waiting for a clock edge. After release, a new capture may take place with new strap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous active-high reset; clears the lock |
| pg_n | input | 1 | Active-low power-good, asynchronous to `clk` |
| fs_a | input | 1 | Frequency select strap, bit 0 |
| fs_b | input | 1 | Frequency select strap, bit 1 |
| fs_c | input | 1 | Frequency select strap, bit 2 |
| tbl_sel | input | 1 | Table-mode strap: 0 = three-input table, 1 = two-input table |
| cpu_code | output | 3 | Latched host clock frequency code |
| src_code | output | 3 | Fixed SRC clock frequency code |
| pci_code | output | 3 | Fixed PCI clock frequency code |
| ref_code | output | 3 | Fixed reference clock frequency code |
| usb_code | output | 3 | Fixed USB clock frequency code |
| rsv_flag | output | 1 | Captured combination is reserved or unused |
| freq_valid | output | 1 | Capture has taken place; outputs are frozen |

## Verification
The bench builds the block with its default synchronizer depth of two stages. This puts the capture edge exactly two edges after the `pg_n` drop and lets that latency be checked directly. With that depth, each of the sixteen strap and table-mode combinations is captured after its own reset, so every table entry is covered. The reserved entry, the unused entries and the `fs_c` don't-care are all reached. After each capture the bench inverts every strap and pulses `pg_n` high and low again, which exercises the one-shot hold. A reset raised between clock edges shows the lock clearing asynchronously.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int FS_W   = 3;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        FQ_100     = 3'd0,
        FQ_133     = 3'd1,
        FQ_200     = 3'd2,
        FQ_266     = 3'd3,
        FQ_33      = 3'd4,
        FQ_14P318  = 3'd5,
        FQ_48      = 3'd6
    } freq_e;

    typedef struct packed {
        logic            narrow;   // 1: two-input table
        logic [FS_W-1:0] fs;       // {c,b,a}
    } strap_t;

    typedef struct packed {
        freq_e cpu;
        logic  rsv;
    } cpu_sel_t;

    localparam freq_e SRC_FIXED = FQ_100;
    localparam freq_e PCI_FIXED = FQ_33;
    localparam freq_e REF_FIXED = FQ_14P318;
    localparam freq_e USB_FIXED = FQ_48;

    // Three-input table: index {c,b,a}
    function automatic cpu_sel_t decode_wide(input logic [FS_W-1:0] fs);
        cpu_sel_t r;
        r.rsv = 1'b0;
        case (fs)
            3'b101:  r.cpu = FQ_100;
            3'b001:  r.cpu = FQ_133;
            3'b010:  r.cpu = FQ_200;
            3'b000:  r.cpu = FQ_266;
            default: begin
                r.cpu = FQ_100;
                r.rsv = 1'b1;
            end
        endcase
        return r;
    endfunction

    // Two-input table: index {b,a}, c not used
    function automatic cpu_sel_t decode_narrow(input logic [1:0] ba);
        cpu_sel_t r;
        r.rsv = 1'b0;
        case (ba)
            2'b00:   r.cpu = FQ_100;
            2'b01:   r.cpu = FQ_133;
            2'b10:   r.cpu = FQ_200;
            default: begin
                r.cpu = FQ_100;
                r.rsv = 1'b1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '1;                 // inactive (high) level
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/strap_lock.sv
module strap_lock
    import strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take,      // synchronized power-good low
    input  strap_t strap_in,
    output strap_t strap_q,
    output logic   locked
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            locked  <= 1'b0;
            strap_q <= '0;
        end else if (!locked && take) begin
            locked  <= 1'b1;
            strap_q <= strap_in;
        end
    end
endmodule

// File: rtl/cpu_table_decode.sv
module cpu_table_decode
    import strap_pkg::*;
(
    input  logic     locked,
    input  strap_t   strap_q,
    output cpu_sel_t sel
);
    cpu_sel_t wide_sel;
    cpu_sel_t narrow_sel;

    always_comb begin
        wide_sel   = decode_wide(strap_q.fs);
        narrow_sel = decode_narrow(strap_q.fs[1:0]);
        if (!locked) begin
            sel.cpu = FQ_100;
            sel.rsv = 1'b0;
        end else if (strap_q.narrow) begin
            sel = narrow_sel;
        end else begin
            sel = wide_sel;
        end
    end
endmodule

// File: rtl/strap_freq_latch.sv
module strap_freq_latch
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pg_n,
    input  logic              fs_a,
    input  logic              fs_b,
    input  logic              fs_c,
    input  logic              tbl_sel,
    output logic [CODE_W-1:0] cpu_code,
    output logic [CODE_W-1:0] src_code,
    output logic [CODE_W-1:0] pci_code,
    output logic [CODE_W-1:0] ref_code,
    output logic [CODE_W-1:0] usb_code,
    output logic              rsv_flag,
    output logic              freq_valid
);
    logic     pg_q;
    logic     pg_low;
    logic     locked;
    strap_t   strap_now;
    strap_t   strap_q;
    cpu_sel_t sel;

    pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pg_n),
        .q_sync  (pg_q)
    );

    assign pg_low = ~pg_q;

    always_comb begin
        strap_now.narrow = tbl_sel;
        strap_now.fs     = {fs_c, fs_b, fs_a};
    end

    strap_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .take     (pg_low),
        .strap_in (strap_now),
        .strap_q  (strap_q),
        .locked   (locked)
    );

    cpu_table_decode u_dec (
        .locked  (locked),
        .strap_q (strap_q),
        .sel     (sel)
    );

    assign cpu_code   = sel.cpu;
    assign rsv_flag   = sel.rsv;
    assign freq_valid = locked;
    assign src_code   = SRC_FIXED;
    assign pci_code   = PCI_FIXED;
    assign ref_code   = REF_FIXED;
    assign usb_code   = USB_FIXED;
endmodule

module strap_freq_latch_chk (
    input logic       clk,
    input logic       rst,
    input logic       pg_low,
    input logic       valid,
    input logic [2:0] cpu,
    input logic       reserved
);
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid); // R3
    AST_FROZEN_OUT: assert property (@(posedge clk) disable iff (rst)
        valid |=> ($stable(cpu) && $stable(reserved))); // R3
    AST_TAKE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        (pg_low && !valid) |=> valid); // R2
    AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (cpu == 3'd0 && !reserved)); // R1
    AST_RSV_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        reserved |-> (cpu == 3'd0)); // R6
endmodule

bind strap_freq_latch strap_freq_latch_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pg_low   (pg_low),
    .valid    (freq_valid),
    .cpu      (cpu_code),
    .reserved (rsv_flag)
);

// File: tb/sim_strap_freq_latch.sv
module sim_strap_freq_latch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pg_n = 1'b1;
    logic       tbl_sel = 1'b0;
    logic [2:0] fs = 3'b000;
    logic [2:0] cpu_code, src_code, pci_code, ref_code, usb_code;
    logic       rsv_flag, freq_valid;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_valid, m_cpu, m_rsv;
    int hist[$];

    strap_freq_latch u0 (
        .clk(clk), .rst(rst), .pg_n(pg_n),
        .fs_a(fs[0]), .fs_b(fs[1]), .fs_c(fs[2]), .tbl_sel(tbl_sel),
        .cpu_code(cpu_code), .src_code(src_code), .pci_code(pci_code),
        .ref_code(ref_code), .usb_code(usb_code),
        .rsv_flag(rsv_flag), .freq_valid(freq_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void expect_sel(input int narrow, input int f,
                                       output int c, output int r);
        r = 0;
        if (narrow != 0) begin
            case (f % 4)
                0: c = 0;
                1: c = 1;
                2: c = 2;
                default: begin c = 0; r = 1; end
            endcase
        end else begin
            case (f)
                5: c = 0;
                1: c = 1;
                2: c = 2;
                0: c = 3;
                default: begin c = 0; r = 1; end
            endcase
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0; m_cpu = 0; m_rsv = 0;
            hist = '{1, 1};
        end else begin
            if (m_valid == 0 && hist[1] == 0) begin
                m_valid = 1;
                expect_sel(int'(tbl_sel), int'(fs), m_cpu, m_rsv);
            end
            hist = '{int'(pg_n), hist[0]};
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: wait for falling edge, compare against model
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R1/R2 model valid", int'(freq_valid), m_valid);
            check("R4/R5 model cpu",   int'(cpu_code), m_cpu);
            check("R6 model rsv",      int'(rsv_flag), m_rsv);
            check("R7 src", int'(src_code), 0);
            check("R7 pci", int'(pci_code), 4);
            check("R7 ref", int'(ref_code), 5);
            check("R7 usb", int'(usb_code), 6);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ec, er;
        hist = '{1, 1};
        m_valid = 0; m_cpu = 0; m_rsv = 0;
        cyc(2);
        check("R1 reset valid", int'(freq_valid), 0);
        check("R1 reset cpu", int'(cpu_code), 0);
        check("R1 reset rsv", int'(rsv_flag), 0);
        rst = 1'b0;
        cyc(3);
        check("R1 idle valid", int'(freq_valid), 0);

        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 8; f++) begin
                // reset raised between edges clears the lock immediately
                #(2);
                rst = 1'b1;
                #(1);
                check("R8 async clear", int'(freq_valid), 0);
                pg_n = 1'b1;
                cyc(2);
                rst = 1'b0;
                tbl_sel = m[0];
                fs = f[2:0];
                cyc(1);
                pg_n = 1'b0;
                cyc(2);
                check("R2 not yet valid", int'(freq_valid), 0);
                cyc(1);
                check("R2 valid at third edge", int'(freq_valid), 1);
                expect_sel(m, f, ec, er);
                if (m == 0) check("R4 wide cpu", int'(cpu_code), ec);
                else        check("R5 narrow cpu", int'(cpu_code), ec);
                check("R6 rsv flag", int'(rsv_flag), er);
                // disturb everything after the lock
                fs = ~f[2:0];
                tbl_sel = ~m[0];
                pg_n = 1'b1;
                cyc(3);
                pg_n = 1'b0;
                cyc(3);
                check("R3 cpu held", int'(cpu_code), ec);
                check("R3 rsv held", int'(rsv_flag), er);
                check("R3 valid held", int'(freq_valid), 1);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule